// File: doc/BRIEF.md
# Oversampled Video Pixel Sampler

The block takes a low-resolution digital colour bus from a retro computer and captures it with a fast sample clock. With a 10 ns sample clock and a 140 ns source pixel, every pixel spans 14 sample slots. The block counts those slots from the start of each line. It takes two samples of every pixel at programmable slot positions and compares them. If the two samples differ, a sample was taken on a data transition or the phase has drifted, and the block raises a mismatch flag.

The slot phase is locked again to every falling edge of the horizontal sync. Phase error therefore cannot build up from one line to the next. A programmable offset, counted in sample clocks, places pixel 0 after the sync edge. Both syncs pass through a two-flop synchroniser. The colour bus is delayed by the same number of flops, so the sample timing can be stated at the pins. The usual slot setting is 5 for the first sample and 9 for the second. A falling edge of the vertical sync ends the line in progress.

Top module: `ovs_pixel_sampler`

## Requirements
- R1: After reset, `pix_valid` and `mismatch` are low, `pix_x` is 0 and `pix_out` is 0.
- R2: Both syncs are active low. Let N be the first rising clock edge at which `hsync_n` is sampled low. Slot s of pixel i is the value of `rgb_in` sampled at edge N + `start_ofs` + 14·i + s.
- R3: The first sample is taken at slot `slot_a` and the second at slot `slot_b`, with 0 ≤ `slot_a` ≤ `slot_b` ≤ 13. The result for pixel i appears for exactly one cycle, starting at clock edge N + `start_ofs` + 14·i + `slot_b` + 2.
- R4: `pix_out` is the first sample when the two samples agree and the second sample when they differ. Samples at every other slot have no effect.
- R5: `mismatch` is high together with `pix_valid` exactly when the two samples differ. It is low whenever `pix_valid` is low.
- R6: `pix_x` runs 0, 1, … 319 across a line, with one strobe per pixel. After pixel 319, no strobe comes until the next falling edge of `hsync_n`.
- R7: `start_ofs` is latched at the sync edge. A value of 0 puts slot 0 of pixel 0 at edge N.
- R8: A falling edge of `hsync_n` during an active line restarts capture at pixel 0, with the phase aligned to the new edge.
- R9: Let M be the first edge at which `vsync_n` is sampled low. Pixels whose second sample lies at an edge up to and including M are still delivered. After that, no strobe comes until the next falling edge of `hsync_n`.
- R10: `pix_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (10 ns) |
| rst_n | input | 1 | Active-low reset |
| rgb_in | input | 12 | Raw colour bus from the source |
| hsync_n | input | 1 | Source horizontal sync, active low |
| vsync_n | input | 1 | Source vertical sync, active low |
| start_ofs | input | 8 | Sample clocks from the sync edge to slot 0 of pixel 0 |
| slot_a | input | 4 | Slot of the first sample |
| slot_b | input | 4 | Slot of the second sample |
| pix_out | output | 12 | Captured pixel value |
| pix_valid | output | 1 | One-cycle strobe per captured pixel |
| pix_x | output | 9 | Index of the captured pixel within the line |
| mismatch | output | 1 | The two samples of this pixel differ |

## Verification
The assertions assume that `slot_a` does not exceed `slot_b` and that both are below 14. They also assume that `slot_a`, `slot_b` and `start_ofs` stay constant during a line. Each sync is assumed to stay high long enough between falling edges for the synchroniser to see every edge.

The stimulus changes the slot positions and the offset only while a sync is low, before the capture window opens. Random slot pairs are drawn in order, so `slot_b` is never below `slot_a`. Every sync pulse and every gap between pulses lasts several cycles, and random glitches are placed only on the colour bus.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int OVS_SLOTS    = 14;
  localparam int OVS_ACTIVE   = 320;
  localparam int OVS_DATA_W   = 12;
  localparam int OVS_OFS_W    = 8;
  localparam int OVS_SYNC_DLY = 2;
  localparam int OVS_SLOT_A_TYP = 5;
  localparam int OVS_SLOT_B_TYP = 9;

  // Two samples of one pixel disagree.
  function automatic logic samples_differ(input logic [OVS_DATA_W-1:0] first,
                                          input logic [OVS_DATA_W-1:0] second);
    return first != second;
  endfunction

  // Keep the first sample on agreement and the later one on disagreement.
  function automatic logic [OVS_DATA_W-1:0] pick_value(input logic [OVS_DATA_W-1:0] first,
                                                       input logic [OVS_DATA_W-1:0] second);
    return samples_differ(first, second) ? second : first;
  endfunction
endpackage

// File: rtl/ovs_sync.sv
module ovs_sync #(
  parameter int LINES = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_n,
  output logic [LINES-1:0] fall
);
  logic [LINES-1:0] stage [DEPTH+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d <= DEPTH; d++) stage[d] <= '1;
    end else begin
      stage[0] <= raw_n;
      for (int d = 1; d <= DEPTH; d++) stage[d] <= stage[d-1];
    end
  end

  // High when the synchronised level has just gone from 1 to 0.
  assign fall = stage[DEPTH] & ~stage[DEPTH-1];
endmodule

// File: rtl/ovs_delay.sv
module ovs_delay #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) pipe[d] <= '0;
    end else begin
      pipe[0] <= din;
      for (int d = 1; d < DEPTH; d++) pipe[d] <= pipe[d-1];
    end
  end

  assign dout = pipe[DEPTH-1];
endmodule

// File: rtl/ovs_phase.sv
module ovs_phase #(
  parameter int SLOTS  = 14,
  parameter int ACTIVE = 320,
  parameter int OFS_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int X_W    = $clog2(ACTIVE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_fall,
  input  logic              vs_fall,
  input  logic [OFS_W-1:0]  start_ofs,
  output logic              active_now,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [X_W-1:0]    cur_x
);
  logic              run_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [SLOT_W-1:0] slot_q;
  logic [X_W-1:0]    x_q;

  logic              cur_run;
  logic [OFS_W-1:0]  cur_ofs;
  logic              slot_last;
  logic              x_last;

  function automatic logic [SLOT_W-1:0] slot_step(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  // A sync edge overrides the stored phase in the same cycle.
  always_comb begin
    if (hs_fall) begin
      cur_run  = 1'b1;
      cur_ofs  = start_ofs;
      cur_slot = '0;
      cur_x    = '0;
    end else begin
      cur_run  = run_q;
      cur_ofs  = ofs_q;
      cur_slot = slot_q;
      cur_x    = x_q;
    end
  end

  assign active_now = cur_run && (cur_ofs == '0);
  assign slot_last  = cur_slot == SLOT_W'(SLOTS - 1);
  assign x_last     = cur_x == X_W'(ACTIVE - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ofs_q  <= '0;
      slot_q <= '0;
      x_q    <= '0;
    end else begin
      run_q  <= cur_run;
      ofs_q  <= cur_ofs;
      slot_q <= cur_slot;
      x_q    <= cur_x;
      if (cur_run) begin
        if (cur_ofs != '0) begin
          ofs_q <= cur_ofs - 1'b1;
        end else begin
          slot_q <= slot_step(cur_slot);
          if (slot_last) begin
            if (x_last) run_q <= 1'b0;
            else        x_q   <= cur_x + 1'b1;
          end
        end
      end
      if (vs_fall && !hs_fall) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ovs_pair.sv
module ovs_pair
  import ovs_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int X_W    = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active_now,
  input  logic [SLOT_W-1:0]     cur_slot,
  input  logic [X_W-1:0]        cur_x,
  input  logic [SLOT_W-1:0]     slot_a,
  input  logic [SLOT_W-1:0]     slot_b,
  input  logic [OVS_DATA_W-1:0] rgb,
  output logic                  take_a,
  output logic                  take_b,
  output logic [OVS_DATA_W-1:0] pix_out,
  output logic                  pix_valid,
  output logic [X_W-1:0]        pix_x,
  output logic                  mismatch
);
  logic [OVS_DATA_W-1:0] first_q;
  logic [OVS_DATA_W-1:0] first_now;

  assign take_a    = active_now && (cur_slot == slot_a);
  assign take_b    = active_now && (cur_slot == slot_b);
  assign first_now = take_a ? rgb : first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= '0;
      pix_out   <= '0;
      pix_valid <= 1'b0;
      pix_x     <= '0;
      mismatch  <= 1'b0;
    end else begin
      if (take_a) first_q <= rgb;
      pix_valid <= take_b;
      mismatch  <= take_b && samples_differ(first_now, rgb);
      if (take_b) begin
        pix_out <= pick_value(first_now, rgb);
        pix_x   <= cur_x;
      end
    end
  end
endmodule

// File: rtl/ovs_pixel_sampler.sv
module ovs_pixel_sampler
  import ovs_pkg::*;
#(
  parameter int SLOTS  = OVS_SLOTS,
  parameter int ACTIVE = OVS_ACTIVE,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int X_W    = $clog2(ACTIVE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OVS_DATA_W-1:0] rgb_in,
  input  logic                  hsync_n,
  input  logic                  vsync_n,
  input  logic [OVS_OFS_W-1:0]  start_ofs,
  input  logic [SLOT_W-1:0]     slot_a,
  input  logic [SLOT_W-1:0]     slot_b,
  output logic [OVS_DATA_W-1:0] pix_out,
  output logic                  pix_valid,
  output logic [X_W-1:0]        pix_x,
  output logic                  mismatch
);
  logic [1:0]            sync_fall;
  logic                  hs_fall;
  logic                  vs_fall;
  logic [OVS_DATA_W-1:0] rgb_al;
  logic                  active_now;
  logic [SLOT_W-1:0]     cur_slot;
  logic [X_W-1:0]        cur_x;
  logic                  take_a;
  logic                  take_b;

  ovs_sync #(.LINES(2), .DEPTH(OVS_SYNC_DLY)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_n({vsync_n, hsync_n}), .fall(sync_fall)
  );
  assign hs_fall = sync_fall[0];
  assign vs_fall = sync_fall[1];

  ovs_delay #(.WIDTH(OVS_DATA_W), .DEPTH(OVS_SYNC_DLY)) u_align (
    .clk(clk), .rst_n(rst_n), .din(rgb_in), .dout(rgb_al)
  );

  ovs_phase #(.SLOTS(SLOTS), .ACTIVE(ACTIVE), .OFS_W(OVS_OFS_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .hs_fall(hs_fall), .vs_fall(vs_fall),
    .start_ofs(start_ofs), .active_now(active_now),
    .cur_slot(cur_slot), .cur_x(cur_x)
  );

  ovs_pair #(.SLOT_W(SLOT_W), .X_W(X_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .active_now(active_now),
    .cur_slot(cur_slot), .cur_x(cur_x), .slot_a(slot_a), .slot_b(slot_b),
    .rgb(rgb_al), .take_a(take_a), .take_b(take_b),
    .pix_out(pix_out), .pix_valid(pix_valid), .pix_x(pix_x), .mismatch(mismatch)
  );
endmodule

// File: rtl/ovs_checker.sv
module ovs_checker #(
  parameter int ACTIVE = 320,
  parameter int X_W    = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hs_fall,
  input logic           vs_fall,
  input logic           pix_valid,
  input logic [X_W-1:0] pix_x,
  input logic           mismatch
);
  logic           fresh_q;
  logic           done_q;
  logic           halted_q;
  logic [X_W-1:0] last_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q  <= 1'b1;
      done_q   <= 1'b0;
      halted_q <= 1'b0;
      last_x   <= '0;
    end else begin
      if (hs_fall)        fresh_q <= 1'b1;
      else if (pix_valid) fresh_q <= 1'b0;
      if (hs_fall) done_q <= 1'b0;
      else if (pix_valid && pix_x == X_W'(ACTIVE - 1)) done_q <= 1'b1;
      if (hs_fall)      halted_q <= 1'b0;
      else if (vs_fall) halted_q <= 1'b1;
      if (pix_valid) last_x <= pix_x;
    end
  end

  // R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  // R5
  flag_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> pix_valid);

  // R6
  x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> pix_x < X_W'(ACTIVE));

  // R8
  x_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fresh_q) |-> pix_x == '0);

  // R6
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !fresh_q) |-> pix_x == last_x + 1'b1);

  // R6
  tail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !hs_fall) |=> !pix_valid);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !hs_fall) |=> !pix_valid);
endmodule

bind ovs_pixel_sampler ovs_checker #(.ACTIVE(ACTIVE), .X_W(X_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_fall(hs_fall), .vs_fall(vs_fall),
  .pix_valid(pix_valid), .pix_x(pix_x), .mismatch(mismatch)
);

// File: tb/ovs_pixel_sampler_test.sv
module ovs_pixel_sampler_test;
  localparam int NSLOT = 14;
  localparam int NPIX  = 320;
  localparam int HSLOW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] rgb_in = '0;
  logic        hsync_n = 1'b1;
  logic        vsync_n = 1'b1;
  logic [7:0]  start_ofs = '0;
  logic [3:0]  slot_a = 4'd5;
  logic [3:0]  slot_b = 4'd9;
  logic [11:0] pix_out;
  logic        pix_valid;
  logic [8:0]  pix_x;
  logic        mismatch;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [11:0] line_rgb [0:4999];

  ovs_pixel_sampler uut (
    .clk(clk), .rst_n(rst_n), .rgb_in(rgb_in), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .start_ofs(start_ofs), .slot_a(slot_a), .slot_b(slot_b),
    .pix_out(pix_out), .pix_valid(pix_valid), .pix_x(pix_x), .mismatch(mismatch)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_value(input logic [11:0] a, input logic [11:0] b);
    if (a == b) return a;
    return b;
  endfunction

  // Fill one line of colour data: a random base per pixel plus glitches.
  task automatic build_line(input int ofs, input int sa, input int sb, input int len,
                            input int glitch_pct);
    for (int n = 0; n < len; n++) line_rgb[n] = 12'($urandom);
    for (int i = 0; i < NPIX; i++) begin
      logic [11:0] base;
      base = 12'($urandom);
      for (int s = 0; s < NSLOT; s++)
        if (ofs + NSLOT*i + s < len) line_rgb[ofs + NSLOT*i + s] = base;
      if (int'($urandom_range(0, 99)) < glitch_pct && ofs + NSLOT*i + sb < len)
        line_rgb[ofs + NSLOT*i + sb] = 12'($urandom);
      // noise in a slot that is not sampled (R4)
      if (int'($urandom_range(0, 99)) < glitch_pct) begin
        int s;
        s = $urandom_range(0, NSLOT-1);
        if (s != sa && s != sb && ofs + NSLOT*i + s < len)
          line_rgb[ofs + NSLOT*i + s] = 12'($urandom);
      end
    end
  endtask

  task automatic check_edge(input int e, input int ofs, input int sa, input int sb,
                            input int vs_at);
    int p, k, i;
    bit ev;
    logic [11:0] a, b;
    p = e - 2;
    k = p - ofs - sb;
    ev = 0;
    i = 0;
    if (p >= 0 && k >= 0 && (k % NSLOT) == 0 && (k / NSLOT) < NPIX &&
        (vs_at < 0 || p <= vs_at)) begin
      ev = 1;
      i = k / NSLOT;
    end
    // R3 R6 R9 R10: strobe timing, count and cut-off
    chk(pix_valid == ev, "R3", "pix_valid", int'(pix_valid), int'(ev));
    if (ev && pix_valid) begin
      a = line_rgb[ofs + NSLOT*i + sa];
      b = line_rgb[ofs + NSLOT*i + sb];
      chk(pix_x == 9'(i), "R6", "pix_x", int'(pix_x), i);
      chk(pix_out == exp_value(a, b), "R4", "pix_out", int'(pix_out), int'(exp_value(a, b)));
      chk(mismatch == (a != b), "R5", "mismatch", int'(mismatch), int'(a != b));
    end else if (!ev) begin
      chk(mismatch == 1'b0, "R5", "mismatch idle", int'(mismatch), 0);
    end
  endtask

  // Drive one line. vs_at < 0 means no vertical sync edge in this line.
  task automatic run_line(input int ofs, input int sa, input int sb, input int len,
                          input int vs_at, input int glitch_pct);
    build_line(ofs, sa, sb, len, glitch_pct);
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      if (n >= 1) check_edge(n - 1, ofs, sa, sb, vs_at);
      if (n == 0) begin
        start_ofs = 8'(ofs);
        slot_a    = 4'(sa);
        slot_b    = 4'(sb);
      end
      hsync_n = (n < HSLOW) ? 1'b0 : 1'b1;
      vsync_n = (vs_at >= 0 && n >= vs_at && n < vs_at + 30) ? 1'b0 : 1'b1;
      rgb_in  = line_rgb[n];
    end
  endtask

  function automatic int full_len(input int ofs);
    return ofs + NSLOT*NPIX + 24;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0B5C));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pix_valid == 1'b0, "R1", "pix_valid", int'(pix_valid), 0);
    chk(mismatch == 1'b0, "R1", "mismatch", int'(mismatch), 0);
    chk(pix_x == '0, "R1", "pix_x", int'(pix_x), 0);
    chk(pix_out == '0, "R1", "pix_out", int'(pix_out), 0);
    repeat (4) @(negedge clk);

    // R2 R3: clean line, typical slots
    run_line(40, 5, 9, full_len(40), -1, 0);
    // R4 R5: glitched line
    run_line(40, 5, 9, full_len(40), -1, 35);
    // R7: zero offset, extreme slots
    run_line(0, 0, 13, full_len(0), -1, 35);
    // R7: largest offset
    run_line(255, 5, 9, full_len(255), -1, 35);
    // R3: both samples on the same slot never mismatch
    run_line(17, 7, 7, full_len(17), -1, 35);
    // R8: cut the line short, the next sync edge restarts at pixel 0
    run_line(30, 5, 9, 30 + NSLOT*100 + 9 + 3, -1, 20);
    run_line(30, 5, 9, full_len(30), -1, 20);
    // R9: vertical sync edge exactly on the second sample of pixel 50
    run_line(30, 5, 9, full_len(30), 30 + NSLOT*50 + 9, 20);
    // R9: vertical sync edge between pixels
    run_line(12, 3, 11, full_len(12), 12 + NSLOT*200 + 4, 20);
    // random settings
    for (int r = 0; r < 3; r++) begin
      int o, a, b;
      o = $urandom_range(0, 255);
      a = $urandom_range(0, NSLOT-1);
      b = $urandom_range(a, NSLOT-1);
      run_line(o, a, b, full_len(o), -1, 40);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule